// File: doc/BRIEF.md
# Display RAM Address Counter

This block keeps the graphics RAM address that a display controller's host data port uses for pixel traffic. Software programs a 16-bit start address through a register write. After that, every pixel write moves the address on by one position inside a rectangular window, so a stream of pixels can be written without new address commands. Pixel reads leave the address where it is.

The address is split into two 8-bit coordinates: the low byte is the column (X) and the high byte is the row (Y). A scan-order bit selects whether the address walks along a row or down a column. A direction bit selects increment or decrement. When the moving coordinate crosses a window edge, it wraps to the opposite edge and the other coordinate takes one step. When the whole window has been covered, the address returns to the window's starting corner.

Two load paths exist. In direct mode a programmed address goes into the counter at once. In RGB-stream mode the address is only staged, and it is copied into the counter at every falling edge of the frame sync, once per frame. Address writes are refused while the device is in standby.

Top module: `gram_addr_counter`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets `addr` and the staged address to 0x0000, so a frame-sync reload after reset gives 0x0000.
- R2: With `rgbMode`=0 and `standby`=0, an address write (`regWrEn`=1) makes `addr` equal `regWrData` after that clock edge.
- R3: While `standby`=1, an address write changes neither `addr` (direct mode) nor the staged value used by later frame reloads (RGB mode).
- R4: With `rgbMode`=1, an address write does not change `addr`. At the first clock edge where `vsync` is sampled low after it was sampled high on the previous edge, `addr` takes the staged value. This happens again on every such edge.
- R5: A pixel read (`pixRd`=1) with no pixel write or load leaves `addr` unchanged.
- R6: With `vertScan`=0 and `incDir`=1, a pixel write increments X. At X = `winXEnd`, X becomes `winXStart` and Y steps +1 (from `winYEnd` it wraps to `winYStart`).
- R7: With `vertScan`=0 and `incDir`=0, a pixel write decrements X. At X = `winXStart`, X becomes `winXEnd` and Y steps -1 (from `winYStart` it wraps to `winYEnd`).
- R8: With `vertScan`=1, a pixel write steps Y in the `incDir` direction. At the Y window edge, Y wraps to the opposite edge and X steps one in the same direction.
- R9: Exhausting the window wraps the address to the starting corner: (`winXStart`,`winYStart`) when incrementing and (`winXEnd`,`winYEnd`) when decrementing, in both scan orders.
- R10: A load in the same cycle as a pixel write wins, and the address does not advance. A frame-sync reload that coincides with an address write uses the value staged before that write, and the new value is applied on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Address register write strobe |
| regWrData | input | 16 | Address value to load ({Y, X}) |
| pixWr | input | 1 | Pixel write strobe; advances the address |
| pixRd | input | 1 | Pixel read strobe; never moves the address |
| standby | input | 1 | Standby mode; refuses address writes |
| rgbMode | input | 1 | 1 = RGB-stream mode (load at frame sync), 0 = direct load |
| incDir | input | 1 | 1 = increment, 0 = decrement |
| vertScan | input | 1 | 1 = step along Y first, 0 = step along X first |
| winXStart | input | 8 | Window left column |
| winXEnd | input | 8 | Window right column |
| winYStart | input | 8 | Window top row |
| winYEnd | input | 8 | Window bottom row |
| vsync | input | 1 | Frame sync; its falling edge triggers the RGB-mode reload |
| addr | output | 16 | Current RAM address ({Y, X}) |

## Verification
Two functions can fall in the same cycle: a pixel-write advance and a load. The load can be the direct register load or the frame-sync reload. The bench raises `pixWr` in the same cycle as a direct address write, and again in the same cycle that `vsync` is sampled low in RGB mode while a new address write arrives. The result is judged by `addr` holding exactly the loaded value with no step applied. In the frame case, that value must be the old staged one, and the newly written address must appear only after the following frame edge.

// File: rtl/gram_addr_pkg.sv
package gram_addr_pkg;
  typedef struct packed {
    logic stage;      // capture a new address into the staging register
    logic loadNow;    // copy written data straight into the counter
    logic loadFrame;  // copy staging register into the counter at frame sync
    logic advance;    // step the counter after a pixel write
  } addrStrobes_t;
endpackage

// File: rtl/gram_axis_step.sv
module gram_axis_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         up,
  input  logic         stepEn,
  output logic [W-1:0] nextPos,
  output logic         wrapped
);
  logic atEdge;

  always_comb begin
    atEdge  = up ? (pos == hi) : (pos == lo);
    wrapped = stepEn && atEdge;
    if (!stepEn)     nextPos = pos;
    else if (atEdge) nextPos = up ? lo : hi;
    else             nextPos = up ? pos + 1'b1 : pos - 1'b1;
  end
endmodule

// File: rtl/gram_addr_ctrl.sv
module gram_addr_ctrl
  import gram_addr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         regWrEn,
  input  logic         pixWr,
  input  logic         standby,
  input  logic         rgbMode,
  input  logic         vsync,
  output addrStrobes_t strobes
);
  logic vsyncQ;
  logic vsyncFall;

  always_ff @(posedge clk) begin
    if (rst) vsyncQ <= 1'b0;
    else     vsyncQ <= vsync;
  end

  always_comb begin
    vsyncFall         = vsyncQ && !vsync;
    strobes.stage     = regWrEn && !standby;
    strobes.loadNow   = regWrEn && !standby && !rgbMode;
    strobes.loadFrame = rgbMode && vsyncFall;
    strobes.advance   = pixWr && !strobes.loadNow && !strobes.loadFrame;
  end
endmodule

// File: rtl/gram_addr_dp.sv
module gram_addr_dp
  import gram_addr_pkg::*;
#(
  parameter int AXIS_W = 8,
  localparam int ADDR_W = 2 * AXIS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  addrStrobes_t      strobes,
  input  logic [ADDR_W-1:0] loadData,
  input  logic              incDir,
  input  logic              vertScan,
  input  logic [AXIS_W-1:0] winXStart,
  input  logic [AXIS_W-1:0] winXEnd,
  input  logic [AXIS_W-1:0] winYStart,
  input  logic [AXIS_W-1:0] winYEnd,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] stagedQ;
  logic [ADDR_W-1:0] stepAddr;

  logic [AXIS_W-1:0] curX, curY;
  logic [AXIS_W-1:0] priPos, priLo, priHi, priNext;
  logic [AXIS_W-1:0] secPos, secLo, secHi, secNext;
  logic              priWrap, secWrap;

  assign curX = addrQ[AXIS_W-1:0];
  assign curY = addrQ[ADDR_W-1:AXIS_W];

  // primary axis moves on every write; secondary only when primary wraps
  always_comb begin
    priPos = vertScan ? curY      : curX;
    priLo  = vertScan ? winYStart : winXStart;
    priHi  = vertScan ? winYEnd   : winXEnd;
    secPos = vertScan ? curX      : curY;
    secLo  = vertScan ? winXStart : winYStart;
    secHi  = vertScan ? winXEnd   : winYEnd;
  end

  gram_axis_step #(.W(AXIS_W)) u_priStep (
    .pos(priPos), .lo(priLo), .hi(priHi), .up(incDir),
    .stepEn(1'b1), .nextPos(priNext), .wrapped(priWrap)
  );

  gram_axis_step #(.W(AXIS_W)) u_secStep (
    .pos(secPos), .lo(secLo), .hi(secHi), .up(incDir),
    .stepEn(priWrap), .nextPos(secNext), .wrapped(secWrap)
  );

  always_comb begin
    if (vertScan) stepAddr = {priNext, secNext};
    else          stepAddr = {secNext, priNext};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stagedQ <= '0;
      addrQ   <= '0;
    end else begin
      if (strobes.stage) stagedQ <= loadData;
      if (strobes.loadFrame)    addrQ <= stagedQ;
      else if (strobes.loadNow) addrQ <= loadData;
      else if (strobes.advance) addrQ <= stepAddr;
    end
  end

  assign addr = addrQ;

  // R6
  hwrap_to_start_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && incDir && !vertScan && curX == winXEnd)
      |=> addrQ[AXIS_W-1:0] == $past(winXStart));

  // R9
  corner_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && incDir && curX == winXEnd && curY == winYEnd)
      |=> addrQ == {$past(winYStart), $past(winXStart)});

  // R8
  vstep_keeps_x_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && vertScan && !secWrap && curY != (incDir ? winYEnd : winYStart))
      |=> addrQ[AXIS_W-1:0] == $past(curX));
endmodule

// File: rtl/gram_addr_counter.sv
module gram_addr_counter
  import gram_addr_pkg::*;
#(
  parameter int AXIS_W = 8,
  localparam int ADDR_W = 2 * AXIS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              pixWr,
  input  logic              pixRd,
  input  logic              standby,
  input  logic              rgbMode,
  input  logic              incDir,
  input  logic              vertScan,
  input  logic [AXIS_W-1:0] winXStart,
  input  logic [AXIS_W-1:0] winXEnd,
  input  logic [AXIS_W-1:0] winYStart,
  input  logic [AXIS_W-1:0] winYEnd,
  input  logic              vsync,
  output logic [ADDR_W-1:0] addr
);
  addrStrobes_t strobes;

  gram_addr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .pixWr(pixWr),
    .standby(standby), .rgbMode(rgbMode), .vsync(vsync), .strobes(strobes)
  );

  gram_addr_dp #(.AXIS_W(AXIS_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .loadData(regWrData),
    .incDir(incDir), .vertScan(vertScan),
    .winXStart(winXStart), .winXEnd(winXEnd),
    .winYStart(winYStart), .winYEnd(winYEnd), .addr(addr)
  );

  // R2
  direct_load_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && !standby && !rgbMode) |=> addr == $past(regWrData));

  // R5
  read_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (pixRd && !pixWr && !regWrEn && (vsync || !rgbMode)) |=> $stable(addr));

  // R3
  standby_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (standby && !rgbMode && !pixWr) |=> $stable(addr));

  // R4
  rgb_defer_chk: assert property (@(posedge clk) disable iff (rst)
    (rgbMode && regWrEn && vsync && !pixWr) |=> $stable(addr));
endmodule

// File: tb/gram_addr_counter_bench.sv
module gram_addr_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {start address, incDir, vertScan, expected after one pixel write}
  // window X 0x10..0x14, Y 0x05..0x08
  localparam logic [33:0] VEC [NVEC] = '{
    {16'h0511, 1'b1, 1'b0, 16'h0512},  // R6 step
    {16'h0514, 1'b1, 1'b0, 16'h0610},  // R6 edge
    {16'h0814, 1'b1, 1'b0, 16'h0510},  // R9 inc H corner
    {16'h0612, 1'b0, 1'b0, 16'h0611},  // R7 step
    {16'h0610, 1'b0, 1'b0, 16'h0514},  // R7 edge
    {16'h0510, 1'b0, 1'b0, 16'h0814},  // R9 dec H corner
    {16'h0612, 1'b1, 1'b1, 16'h0712},  // R8 step
    {16'h0812, 1'b1, 1'b1, 16'h0513},  // R8 edge
    {16'h0814, 1'b1, 1'b1, 16'h0510},  // R9 inc V corner
    {16'h0712, 1'b0, 1'b1, 16'h0612},  // R8 dec step
    {16'h0512, 1'b0, 1'b1, 16'h0811},  // R8 dec edge
    {16'h0510, 1'b0, 1'b1, 16'h0814}   // R9 dec V corner
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0, pixWr = 1'b0, pixRd = 1'b0, standby = 1'b0;
  logic rgbMode = 1'b0, incDir = 1'b1, vertScan = 1'b0, vsync = 1'b0;
  logic [15:0] regWrData = '0;
  logic [7:0] winXStart = 8'h10, winXEnd = 8'h14, winYStart = 8'h05, winYEnd = 8'h08;
  logic [15:0] addr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gram_addr_counter u_gram_addr_counter (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regWrData(regWrData),
    .pixWr(pixWr), .pixRd(pixRd), .standby(standby), .rgbMode(rgbMode),
    .incDir(incDir), .vertScan(vertScan),
    .winXStart(winXStart), .winXEnd(winXEnd),
    .winYStart(winYStart), .winYEnd(winYEnd),
    .vsync(vsync), .addr(addr)
  );

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (addr !== exp) begin
      fails++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeAddr(input logic [15:0] d);
    regWrEn = 1'b1; regWrData = d; tick(); regWrEn = 1'b0;
  endtask

  task automatic pixelWrite();
    pixWr = 1'b1; tick(); pixWr = 1'b0;
  endtask

  task automatic frameEdge();
    vsync = 1'b1; tick(); tick(); vsync = 1'b0; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R1 reset", 16'h0000);
    rgbMode = 1'b1;
    pixelWrite();
    check("R6 advance from reset", 16'h0001);
    frameEdge();
    check("R1 staged reset", 16'h0000);
    rgbMode = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      incDir = VEC[i][17]; vertScan = VEC[i][16];
      writeAddr(VEC[i][33:18]);
      check("R2 load", VEC[i][33:18]);
      pixelWrite();
      check("R6/R7/R8/R9 step", VEC[i][15:0]);
    end
    incDir = 1'b1; vertScan = 1'b0;

    writeAddr(16'h0612);
    pixRd = 1'b1; tick(); tick(); pixRd = 1'b0;
    check("R5 read", 16'h0612);

    standby = 1'b1; writeAddr(16'h0711); standby = 1'b0;
    check("R3 standby direct", 16'h0612);

    regWrEn = 1'b1; regWrData = 16'h0611; pixWr = 1'b1; tick();
    regWrEn = 1'b0; pixWr = 1'b0;
    check("R10 load beats advance", 16'h0611);

    rgbMode = 1'b1;
    vsync = 1'b1; tick();
    writeAddr(16'h0713);
    check("R4 deferred", 16'h0611);
    vsync = 1'b0; tick();
    check("R4 frame load", 16'h0713);
    pixelWrite();
    check("R6 advance in rgb", 16'h0714);
    frameEdge();
    check("R4 every frame", 16'h0713);

    standby = 1'b1; writeAddr(16'h0810); standby = 1'b0;
    pixelWrite();
    frameEdge();
    check("R3 standby staged", 16'h0713);

    vsync = 1'b1; tick(); tick();
    vsync = 1'b0; regWrEn = 1'b1; regWrData = 16'h0512; pixWr = 1'b1; tick();
    regWrEn = 1'b0; pixWr = 1'b0;
    check("R10 frame uses old staged", 16'h0713);
    frameEdge();
    check("R10 new value next frame", 16'h0512);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: addr=%h expected=done", addr);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule